// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command decoder and write sequencer of a byte-wide boot-block flash memory, written as synchronous logic. A host issues single-cycle bus writes that carry command bytes, and single-cycle bus reads. The controller picks the read source: array data, the status byte or identifier codes. It runs two-write byte program and block erase sequences and lets a running erase be paused so that the array can be read. It refuses program and erase aimed at the boot block unless the hardware unlock input is high.

The storage array sits behind a plain request port. A program or erase request stays high until the array returns a one-cycle done pulse with a pass/fail flag. The pause output freezes an erase in progress. While the array is not programming, the array address follows the bus address, so the array can serve reads combinationally.

The state machine has six states. ST_IDLE is ready and decodes single-cycle commands. ST_PGM_SETUP waits for the address/data write after 40H. ST_ERS_SETUP waits for the confirm write after 20H. ST_PGM_RUN and ST_ERS_RUN hold an array request until done. ST_ERS_SUSP holds a paused erase. The transitions are as follows. ST_IDLE goes to ST_PGM_SETUP on 40H and to ST_ERS_SETUP on 20H. ST_PGM_SETUP goes to ST_PGM_RUN when the write is accepted and back to ST_IDLE when it is refused. ST_ERS_SETUP goes to ST_ERS_RUN on an accepted D0H and back to ST_IDLE when the write is refused or a sequence error occurs. ST_PGM_RUN and ST_ERS_RUN return to ST_IDLE on done. ST_ERS_RUN goes to ST_ERS_SUSP on B0H, and ST_ERS_SUSP returns to ST_ERS_RUN on D0H.

Top module: `flashcmd_ctrl`

## Requirements
- R1: After reset, no array request or pause is active, bus_rdata is 00H, the read source is the array, and the status byte reads 80H.
- R2: After command FFH, a read returns the array data for the bus address, one cycle after the read strobe.
- R3: After command 90H, a read returns 89H when address bit 0 is 0 and 7CH when it is 1.
- R4: After command 70H, every read returns the status byte at any address. Bit 7 is ready, bit 6 is erase suspended, bit 5 is erase error, bit 4 is program error, bit 3 is supply fault and bit 1 is boot lock error. Bits 2 and 0 read 0.
- R5: Writing 40H and then a write that carries an address and a data byte raises arr_prog_req with those values captured on arr_addr and arr_wdata. The request holds until arr_done, status bit 7 reads 0 meanwhile, and reads return status from the 40H write onward.
- R6: Writing 20H and then D0H raises arr_erase_req with arr_blk set to the block that holds the address. Block 0 is 00000H-1FFFFH, block 1 is 20000H-37FFFH, block 2 is 38000H-39FFFH, block 3 is 3A000H-3BFFFH and block 4 (boot) is 3C000H-3FFFFH.
- R7: A second erase write other than D0H sets status bits 5 and 4, starts no erase, and returns the controller to ready.
- R8: A program or erase aimed at block 4 while boot_unlock is low sets bit 1, plus bit 4 (program) or bit 5 (erase), and starts nothing. With boot_unlock high the operation runs.
- R9: A program or erase confirmed while vpp_ok is low sets bit 3, plus bit 4 (program) or bit 5 (erase), and starts nothing.
- R10: arr_done with arr_fail high sets bit 4 after a program and bit 5 after an erase.
- R11: While a program or erase runs, only 70H, B0H and D0H are acted on. Other commands, such as FFH, 40H and 50H, have no effect, and B0H has no effect during a program.
- R12: B0H during an erase raises arr_pause, and status reads C0H. Array reads are then allowed after FFH. D0H drops the pause, clears bit 6 and resumes the erase.
- R13: D0H written while ready with no suspended erase has no effect: no request is raised and the status is unchanged.
- R14: Command 50H, written while ready, clears status bits 5, 4, 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Single-cycle bus write strobe |
| bus_re | input | 1 | Single-cycle bus read strobe |
| bus_addr | input | 18 | Bus byte address |
| bus_wdata | input | 8 | Bus write data or command byte |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_re |
| boot_unlock | input | 1 | High allows program/erase of the boot block |
| vpp_ok | input | 1 | Programming supply within range |
| arr_prog_req | output | 1 | Byte program request, held until done |
| arr_erase_req | output | 1 | Block erase request, held until done |
| arr_pause | output | 1 | Freeze the running erase |
| arr_addr | output | 18 | Program address, or the bus address when not programming |
| arr_wdata | output | 8 | Byte to program |
| arr_blk | output | 3 | Index of the block to erase |
| arr_rdata | input | 8 | Array read data for arr_addr |
| arr_done | input | 1 | One-cycle completion pulse |
| arr_fail | input | 1 | Operation failed, valid with arr_done |

## Verification
Array reads are swept over 64 addresses spread across every block, and identifier reads are tried at several addresses with each value of bit 0. Together these separate the three read sources and show that only bit 0 selects the identifier code. Erase is swept over 64 addresses, one per 4 KB step, and each expected block index comes from the range arithmetic, so every block boundary is crossed. Each refusal cause is then triggered in isolation: boot lock, supply fault, bad confirm byte and array failure. The status byte read after each one separates the four error encodings, and a suspend/resume run combined with ignored commands during busy periods shows which writes the busy states act on.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;
    localparam int BLK_W  = 3;

    // block sizes in KB, counted downward from the top of the array
    localparam int BOOT_KB   = 16;
    localparam int PARAM_KB  = 8;
    localparam int MAIN_A_KB = 96;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_SR    = 8'h70;
    localparam logic [7:0] CMD_CLR_SR     = 8'h50;
    localparam logic [7:0] CMD_PGM        = 8'h40;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

    localparam logic [7:0] ID_MFR = 8'h89;
    localparam logic [7:0] ID_DEV = 8'h7C;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PGM_SETUP, ST_ERS_SETUP, ST_PGM_RUN, ST_ERS_RUN, ST_ERS_SUSP
    } fsm_t;

    typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS} rmode_t;
endpackage

// File: rtl/flashcmd_blkmap.sv
module flashcmd_blkmap
    import flashcmd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BLK_W
) (
    input  logic [AW-1:0] addr,
    output logic [BW-1:0] blk_idx,
    output logic          is_boot
);
    localparam int NBASE = 4;
    localparam longint TOP       = longint'(1) << AW;
    localparam longint BOOT_BASE = TOP - BOOT_KB * 1024;
    localparam longint P1_BASE   = BOOT_BASE - PARAM_KB * 1024;
    localparam longint P0_BASE   = P1_BASE - PARAM_KB * 1024;
    localparam longint M1_BASE   = P0_BASE - MAIN_A_KB * 1024;

    function automatic longint base_of(int k);
        case (k)
            0:       return M1_BASE;
            1:       return P0_BASE;
            2:       return P1_BASE;
            default: return BOOT_BASE;
        endcase
    endfunction

    logic [NBASE-1:0] above;
    longint a64;
    assign a64 = longint'(addr);

    genvar g;
    generate
        for (g = 0; g < NBASE; g++) begin : g_cmp
            assign above[g] = (a64 >= base_of(g));
        end
    endgenerate

    // bases ascend, so the count of bases at or below the address is the index
    always_comb begin
        blk_idx = '0;
        for (int k = 0; k < NBASE; k++) begin
            if (above[k]) blk_idx = BW'(k + 1);
        end
    end

    assign is_boot = above[NBASE-1];
endmodule

// File: rtl/flashcmd_status.sv
module flashcmd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_pgm,
    input  logic       set_ers,
    input  logic       set_vpp,
    input  logic       set_lock,
    input  logic       ready,
    input  logic       susp,
    output logic [7:0] sr
);
    logic ers_err, pgm_err, vpp_err, lock_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ers_err  <= 1'b0;
            pgm_err  <= 1'b0;
            vpp_err  <= 1'b0;
            lock_err <= 1'b0;
        end else if (clr) begin
            ers_err  <= 1'b0;
            pgm_err  <= 1'b0;
            vpp_err  <= 1'b0;
            lock_err <= 1'b0;
        end else begin
            ers_err  <= ers_err  | set_ers;
            pgm_err  <= pgm_err  | set_pgm;
            vpp_err  <= vpp_err  | set_vpp;
            lock_err <= lock_err | set_lock;
        end
    end

    assign sr = {ready, susp, ers_err, pgm_err, vpp_err, 1'b0, lock_err, 1'b0};

    // R14: a clear leaves all four error flags low on the next cycle
    a_r14_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sr[5:3] == 3'b000 && !sr[1]));

    // R4: an erase cannot be both suspended and busy
    a_r4_susp_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sr[6] |-> sr[7]);
endmodule

// File: rtl/flashcmd_rdmux.sv
module flashcmd_rdmux
    import flashcmd_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          re,
    input  rmode_t        mode,
    input  logic          addr_lsb,
    input  logic [DW-1:0] arr_rdata,
    input  logic [7:0]    sr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] sel;

    always_comb begin
        unique case (mode)
            RM_ARRAY:  sel = arr_rdata;
            RM_ID:     sel = addr_lsb ? DW'(ID_DEV) : DW'(ID_MFR);
            RM_STATUS: sel = DW'(sr);
            default:   sel = arr_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= sel;
    end

    // R3: identifier reads yield only the two codes
    a_r3_id_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (re && mode == RM_ID) |=> (rdata == DW'(ID_MFR) || rdata == DW'(ID_DEV)));

    // R2: without a read strobe the read data holds
    a_r2_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
    import flashcmd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int BW = BLK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic          bus_re,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          boot_unlock,
    input  logic          vpp_ok,
    output logic          arr_prog_req,
    output logic          arr_erase_req,
    output logic          arr_pause,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic [BW-1:0] arr_blk,
    input  logic [DW-1:0] arr_rdata,
    input  logic          arr_done,
    input  logic          arr_fail
);
    fsm_t   st, st_nxt;
    rmode_t rmode, rmode_nxt;

    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic [BW-1:0] cap_blk;
    logic          load_cap;
    logic          s_pgm, s_ers, s_vpp, s_lock, s_clr;
    logic [BW-1:0] blk_idx;
    logic          blk_boot;
    logic          boot_locked;
    logic [7:0]    sr;
    logic [7:0]    cmd;
    logic          ready, susp;

    assign cmd         = bus_wdata[7:0];
    assign boot_locked = blk_boot && !boot_unlock;

    flashcmd_blkmap #(.AW(AW), .BW(BW)) blkmap_i (
        .addr    (bus_addr),
        .blk_idx (blk_idx),
        .is_boot (blk_boot)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            rmode <= RM_ARRAY;
        end else begin
            st    <= st_nxt;
            rmode <= rmode_nxt;
        end
    end

    // captured operands of the accepted second write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_blk  <= '0;
        end else if (load_cap) begin
            cap_addr <= bus_addr;
            cap_data <= bus_wdata;
            cap_blk  <= blk_idx;
        end
    end

    // next state, read source and status events
    always_comb begin
        st_nxt    = st;
        rmode_nxt = rmode;
        load_cap  = 1'b0;
        s_pgm     = 1'b0;
        s_ers     = 1'b0;
        s_vpp     = 1'b0;
        s_lock    = 1'b0;
        s_clr     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY: rmode_nxt = RM_ARRAY;
                        CMD_READ_ID:    rmode_nxt = RM_ID;
                        CMD_READ_SR:    rmode_nxt = RM_STATUS;
                        CMD_CLR_SR:     s_clr = 1'b1;
                        CMD_PGM: begin
                            st_nxt    = ST_PGM_SETUP;
                            rmode_nxt = RM_STATUS;
                        end
                        CMD_ERASE: begin
                            st_nxt    = ST_ERS_SETUP;
                            rmode_nxt = RM_STATUS;
                        end
                        default: ;
                    endcase
                end
            end
            ST_PGM_SETUP: begin
                if (bus_we) begin
                    if (boot_locked) begin
                        s_pgm  = 1'b1;
                        s_lock = 1'b1;
                        st_nxt = ST_IDLE;
                    end else if (!vpp_ok) begin
                        s_pgm  = 1'b1;
                        s_vpp  = 1'b1;
                        st_nxt = ST_IDLE;
                    end else begin
                        load_cap = 1'b1;
                        st_nxt   = ST_PGM_RUN;
                    end
                end
            end
            ST_ERS_SETUP: begin
                if (bus_we) begin
                    if (cmd != CMD_CONFIRM) begin
                        s_pgm  = 1'b1;
                        s_ers  = 1'b1;
                        st_nxt = ST_IDLE;
                    end else if (boot_locked) begin
                        s_ers  = 1'b1;
                        s_lock = 1'b1;
                        st_nxt = ST_IDLE;
                    end else if (!vpp_ok) begin
                        s_ers  = 1'b1;
                        s_vpp  = 1'b1;
                        st_nxt = ST_IDLE;
                    end else begin
                        load_cap = 1'b1;
                        st_nxt   = ST_ERS_RUN;
                    end
                end
            end
            ST_PGM_RUN: begin
                if (bus_we && cmd == CMD_READ_SR) rmode_nxt = RM_STATUS;
                if (arr_done) begin
                    s_pgm  = arr_fail;
                    st_nxt = ST_IDLE;
                end
            end
            ST_ERS_RUN: begin
                if (bus_we && cmd == CMD_READ_SR) rmode_nxt = RM_STATUS;
                if (arr_done) begin
                    s_ers  = arr_fail;
                    st_nxt = ST_IDLE;
                end else if (bus_we && cmd == CMD_SUSPEND) begin
                    st_nxt = ST_ERS_SUSP;
                end
            end
            ST_ERS_SUSP: begin
                if (bus_we) begin
                    case (cmd)
                        CMD_READ_ARRAY: rmode_nxt = RM_ARRAY;
                        CMD_READ_ID:    rmode_nxt = RM_ID;
                        CMD_READ_SR:    rmode_nxt = RM_STATUS;
                        CMD_CONFIRM:    st_nxt = ST_ERS_RUN;
                        default: ;
                    endcase
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        arr_prog_req  = (st == ST_PGM_RUN);
        arr_erase_req = (st == ST_ERS_RUN) || (st == ST_ERS_SUSP);
        arr_pause     = (st == ST_ERS_SUSP);
        arr_addr      = (st == ST_PGM_RUN) ? cap_addr : bus_addr;
        arr_wdata     = cap_data;
        arr_blk       = cap_blk;
        ready         = (st != ST_PGM_RUN) && (st != ST_ERS_RUN);
        susp          = (st == ST_ERS_SUSP);
    end

    flashcmd_status status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (s_clr),
        .set_pgm  (s_pgm),
        .set_ers  (s_ers),
        .set_vpp  (s_vpp),
        .set_lock (s_lock),
        .ready    (ready),
        .susp     (susp),
        .sr       (sr)
    );

    flashcmd_rdmux #(.DW(DW)) rdmux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .re        (bus_re),
        .mode      (rmode),
        .addr_lsb  (bus_addr[0]),
        .arr_rdata (arr_rdata),
        .sr        (sr),
        .rdata     (bus_rdata)
    );

    // R5: never program and erase at once
    a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_prog_req, arr_erase_req}));

    // R5: status shows busy while a program is outstanding
    a_r5_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        arr_prog_req |-> !sr[7]);

    // R12: the pause only accompanies an erase
    a_r12_pause_in_erase: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pause |-> arr_erase_req);

    // R8: locked boot program is refused with lock error
    a_r8_boot_prog_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM_SETUP && bus_we && blk_boot && !boot_unlock)
        |=> (!arr_prog_req && sr[4] && sr[1]));

    // R7: a bad confirm byte sets both error bits and starts nothing
    a_r7_seq_error: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_SETUP && bus_we && cmd != CMD_CONFIRM)
        |=> (sr[5] && sr[4] && !arr_erase_req));

    // R13: a confirm byte while ready starts no erase
    a_r13_resume_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_we && cmd == CMD_CONFIRM) |=> !arr_erase_req);
endmodule

// File: tb/flashcmd_ctrl_tb_top.sv
module flashcmd_ctrl_tb_top;
    localparam int AW  = 18;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [17:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        boot_unlock = 1'b0, vpp_ok = 1'b1;
    logic        arr_prog_req, arr_erase_req, arr_pause;
    logic [17:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic [2:0]  arr_blk;
    logic [7:0]  arr_rdata;
    logic        arr_done = 1'b0;
    logic        arr_fail = 1'b0;
    logic        mdl_en = 1'b1, fail_next = 1'b0;
    int          cnt = 0;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    flashcmd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .boot_unlock(boot_unlock), .vpp_ok(vpp_ok),
        .arr_prog_req(arr_prog_req), .arr_erase_req(arr_erase_req),
        .arr_pause(arr_pause), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_blk(arr_blk), .arr_rdata(arr_rdata), .arr_done(arr_done),
        .arr_fail(arr_fail)
    );

    function automatic logic [7:0] mem_val(logic [17:0] a);
        return a[7:0] ^ a[15:8] ^ {6'b0, a[17:16]};
    endfunction

    function automatic logic [2:0] exp_blk(int a);
        if (a < 'h20000) return 3'd0;
        if (a < 'h38000) return 3'd1;
        if (a < 'h3A000) return 3'd2;
        if (a < 'h3C000) return 3'd3;
        return 3'd4;
    endfunction

    assign arr_rdata = mem_val(arr_addr);

    // array model: completes LAT cycles after a request unless paused or disabled
    always @(posedge clk) begin
        arr_done <= 1'b0;
        if ((arr_prog_req || arr_erase_req) && !arr_pause && mdl_en && !arr_done) begin
            if (cnt == LAT) begin
                arr_done <= 1'b1;
                arr_fail <= fail_next;
                cnt      <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [17:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [17:0] a);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            if (!arr_prog_req && !arr_erase_req) break;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 prog_req", arr_prog_req, 0);
        check("R1 erase_req", arr_erase_req, 0);
        check("R1 pause", arr_pause, 0);
        check("R1 rdata", bus_rdata, 0);
        rst_n = 1'b1;
        rd(18'h00123);
        check("R1 default array read", bus_rdata, mem_val(18'h00123));
        wr(0, 8'h70);
        rd(18'h2ABCD);
        check("R1 status after reset", bus_rdata, 8'h80);
        // R4 status at any address
        rd(18'h00000); check("R4 status addr0", bus_rdata, 8'h80);
        rd(18'h3FFFF); check("R4 status top", bus_rdata, 8'h80);
        // R3 identifier
        wr(0, 8'h90);
        rd(18'h00000); check("R3 mfr code", bus_rdata, 8'h89);
        rd(18'h00001); check("R3 dev code", bus_rdata, 8'h7C);
        rd(18'h3FFFF); check("R3 odd address", bus_rdata, 8'h7C);
        rd(18'h12340); check("R3 even address", bus_rdata, 8'h89);
        // R2 array sweep
        wr(0, 8'hFF);
        for (int i = 0; i < 64; i++) begin
            logic [17:0] a;
            a = 18'(i * 'h1000 + i * 37);
            rd(a);
            check("R2 array read", bus_rdata, mem_val(a));
        end
        // R5 program
        mdl_en = 1'b0;
        wr(0, 8'h40);
        wr(18'h01234, 8'hA5);
        check("R5 prog_req", arr_prog_req, 1);
        check("R5 prog addr", arr_addr, 18'h01234);
        check("R5 prog data", arr_wdata, 8'hA5);
        rd(18'h00055); check("R5 busy status", bus_rdata, 8'h00);
        // R11 ignored commands while busy
        wr(0, 8'hFF);
        wr(0, 8'h50);
        wr(0, 8'hB0);
        rd(18'h00055); check("R11 FFH ignored busy", bus_rdata, 8'h00);
        check("R11 B0H ignored in program", arr_pause, 0);
        check("R11 still programming", arr_prog_req, 1);
        mdl_en = 1'b1;
        wait_idle();
        rd(0); check("R5 done status", bus_rdata, 8'h80);
        // R10 program failure, R14 clear
        fail_next = 1'b1;
        wr(0, 8'h40); wr(18'h00010, 8'h3C);
        wait_idle(); fail_next = 1'b0;
        rd(0); check("R10 program fail", bus_rdata, 8'h90);
        wr(0, 8'h50);
        rd(0); check("R14 clear after prog fail", bus_rdata, 8'h80);
        // R8 boot lock
        wr(0, 8'h40); wr(18'h3C000, 8'h11);
        check("R8 locked prog no req", arr_prog_req, 0);
        rd(0); check("R8 locked prog status", bus_rdata, 8'h92);
        wr(0, 8'h50);
        wr(0, 8'h20); wr(18'h3E000, 8'hD0);
        check("R8 locked erase no req", arr_erase_req, 0);
        rd(0); check("R8 locked erase status", bus_rdata, 8'hA2);
        wr(0, 8'h50);
        // R7 sequence error
        wr(0, 8'h20); wr(18'h00000, 8'hFF);
        check("R7 no erase", arr_erase_req, 0);
        rd(0); check("R7 status", bus_rdata, 8'hB0);
        wr(0, 8'h50);
        rd(0); check("R14 clear after seq error", bus_rdata, 8'h80);
        // R9 supply fault
        vpp_ok = 1'b0;
        wr(0, 8'h40); wr(18'h00020, 8'h01);
        check("R9 prog no req", arr_prog_req, 0);
        rd(0); check("R9 prog status", bus_rdata, 8'h98);
        wr(0, 8'h50);
        wr(0, 8'h20); wr(18'h00020, 8'hD0);
        check("R9 erase no req", arr_erase_req, 0);
        rd(0); check("R9 erase status", bus_rdata, 8'hA8);
        wr(0, 8'h50);
        vpp_ok = 1'b1;
        // R6 erase sweep with boot unlocked (R8 unlocked path)
        boot_unlock = 1'b1;
        for (int i = 0; i < 64; i++) begin
            int a;
            a = i * 'h1000 + 'hA5;
            wr(0, 8'h20); wr(18'(a), 8'hD0);
            check("R6 erase_req", arr_erase_req, 1);
            check("R6 block index", arr_blk, exp_blk(a));
            wait_idle();
        end
        boot_unlock = 1'b0;
        rd(0); check("R6 status after sweep", bus_rdata, 8'h80);
        // R10 erase failure
        fail_next = 1'b1;
        wr(0, 8'h20); wr(0, 8'hD0);
        wait_idle(); fail_next = 1'b0;
        rd(0); check("R10 erase fail", bus_rdata, 8'hA0);
        wr(0, 8'h50);
        // R12 suspend / resume
        mdl_en = 1'b0;
        wr(0, 8'h20); wr(18'h20000, 8'hD0);
        rd(0); check("R12 erase busy", bus_rdata, 8'h00);
        wr(0, 8'h40);
        check("R11 40H ignored in erase", arr_prog_req, 0);
        wr(0, 8'hB0);
        check("R12 pause", arr_pause, 1);
        rd(0); check("R12 suspended status", bus_rdata, 8'hC0);
        wr(0, 8'hFF);
        rd(18'h00ABC); check("R12 array read in suspend", bus_rdata, mem_val(18'h00ABC));
        wr(0, 8'hD0);
        check("R12 pause released", arr_pause, 0);
        check("R12 erase resumed", arr_erase_req, 1);
        wr(0, 8'h70);
        rd(0); check("R12 resumed status", bus_rdata, 8'h00);
        mdl_en = 1'b1;
        wait_idle();
        rd(0); check("R12 erase finished", bus_rdata, 8'h80);
        // R13 resume with nothing suspended
        wr(0, 8'hD0);
        check("R13 no erase", arr_erase_req, 0);
        rd(0); check("R13 status unchanged", bus_rdata, 8'h80);
        finish_run();
    end
endmodule